// File: doc/BRIEF.md
# Four-Phase External Memory Bus Interface

This block connects a processor core to an external 16-bit memory bus. Every instruction cycle is split into four phases, t0 to t3. Each phase lasts one clock period. The core may request one external access per instruction cycle. A request carries an address, a read/write direction, a memory-space select (program or data) and write data. The block drives the address bus, the memory-space select line and the bidirectional data bus. Each tri-state pin is modelled as a value and output-enable pair.

Requests are sampled on the clock edge that starts t0. Once sampled, a request is held for the whole four-phase cycle. A write puts its data on the bus only during t2 and t3. A read captures the bus at the end of t2 and returns the value to the core with a one-cycle valid pulse during t3. The address holds its last value while the bus is idle, and the select line parks high. All pins float during reset. The address and select pins also float while the unit does not hold bus mastership.

Top module: `xbus_phase_unit`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `xa_oe_o`, `msel_oe_o`, `xd_oe_o` and `rd_valid_o` are 0 and `phase_o` is 0 (t0).
- R2: `phase_o` encodes t0..t3 as 0..3. The period in which `rst` is first low is t0. After that the phase advances by one on every clock and wraps from 3 to 0.
- R3: The request inputs are sampled on the edge that ends t3 and starts t0. An accepted request puts `acc_addr_i` on `xa_o` during t0, and it stays there through t3 even if the inputs change.
- R4: When no access is accepted at a t0 start, `xa_o` keeps its previous value.
- R5: `xa_oe_o` and `msel_oe_o` equal the value of `bus_master_i` sampled at the previous edge. Both are 0 in reset.
- R6: `msel_o` changes only at a t0 start. It is 1 for a program-space access (`acc_dspace_i`=0), 0 for a data-space access (`acc_dspace_i`=1), and 1 when no access is accepted.
- R7: For an accepted write (`acc_wr_i`=1), `xd_oe_o` is 1 exactly during t2 and t3, and `xd_o` carries the write data sampled at the t0 start.
- R8: `xd_oe_o` is 0 in t0 and t1, and is 0 in every phase of an idle cycle or a read cycle.
- R9: For an accepted read, `xd_i` is captured on the edge that ends t2. `rd_valid_o` is 1 only during the following t3, with `rd_data_o` equal to the captured value.
- R10: A request is accepted only if `acc_req_i` and `bus_master_i` are both 1 at the t0 start edge. A refused request drives no data and raises no read valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| bus_master_i | input | 1 | Unit holds bus mastership |
| acc_req_i | input | 1 | Core requests an external access |
| acc_addr_i | input | 16 | Access address |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_dspace_i | input | 1 | 1 = data space, 0 = program space |
| acc_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Captured read data |
| rd_valid_o | output | 1 | Read data valid (t3 of a read) |
| phase_o | output | 2 | Current phase, 0..3 |
| xa_o | output | 16 | External address value |
| xa_oe_o | output | 1 | External address drive enable |
| msel_o | output | 1 | Memory space select value (1 program, 0 data) |
| msel_oe_o | output | 1 | Memory space select drive enable |
| xd_o | output | 16 | External data value driven on writes |
| xd_oe_o | output | 1 | External data drive enable |
| xd_i | input | 16 | External data bus as seen at the pins |

## Verification
A phase counter that slips shows up within four clocks. The sample edge moves, so the address changes outside t0 and the data enable rises outside t2. A lost or stale latched direction shows up in the same cycle as a data enable during a read, or as a read-valid pulse after a write. A wrong address or select hold appears at the first idle t0 after an access, where the held address or the parked-high select is compared directly.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_T0 = 2'd0,
    PH_T1 = 2'd1,
    PH_T2 = 2'd2,
    PH_T3 = 2'd3
  } xb_phase_e;

  typedef struct packed {
    logic act;
    logic wr;
    logic dsp;
  } xb_ctl_t;
endpackage

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq
  import xbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output xb_phase_e phase,
  output logic      cyc_start,
  output logic      t1_end,
  output logic      t2_end
);
  xb_phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_T0;
    else     ph_q <= xb_phase_e'(ph_q + 2'd1);
  end

  assign phase     = ph_q;
  assign cyc_start = (ph_q == PH_T3);
  assign t1_end    = (ph_q == PH_T1);
  assign t2_end    = (ph_q == PH_T2);

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T3) |=> (ph_q == PH_T0));
  assert_phase_restart_R2: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (ph_q == PH_T0));
endmodule

// File: rtl/xbus_addr_drv.sv
module xbus_addr_drv
  import xbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mstr,
  input  logic          cyc_start,
  input  logic          req,
  input  logic          wr,
  input  logic          dsp,
  input  logic [AW-1:0] addr_in,
  output xb_ctl_t       ctl,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic          sel_o,
  output logic          sel_oe
);
  logic          take;
  logic [AW-1:0] addr_q;
  logic          sel_q;
  logic          oe_q;
  xb_ctl_t       ctl_q;

  assign take = req && mstr;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b1;
      oe_q   <= 1'b0;
      ctl_q  <= '0;
    end else begin
      oe_q <= mstr;
      if (cyc_start) begin
        ctl_q.act <= take;
        ctl_q.wr  <= wr;
        ctl_q.dsp <= dsp;
        sel_q     <= take ? !dsp : 1'b1;
        if (take) addr_q <= addr_in;
      end
    end
  end

  assign ctl     = ctl_q;
  assign addr_o  = addr_q;
  assign addr_oe = oe_q;
  assign sel_o   = sel_q;
  assign sel_oe  = oe_q;

  assert_addr_hold_mid_R3: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(addr_q));
  assert_addr_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !take) |=> $stable(addr_q));
  assert_sel_park_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !take) |=> sel_q);
  assert_sel_mid_R6: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(sel_q));
  assert_refused_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !mstr) |=> !ctl_q.act);
endmodule

// File: rtl/xbus_data_drv.sv
module xbus_data_drv
  import xbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  xb_phase_e     phase,
  input  logic          cyc_start,
  input  logic          t1_end,
  input  logic          t2_end,
  input  xb_ctl_t       ctl,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;
  logic          oe_q;
  logic          rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q <= '0;
      rd_q <= '0;
      oe_q <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      if (cyc_start) wd_q <= wdata_in;
      if (t1_end)         oe_q <= ctl.act && ctl.wr;
      else if (cyc_start) oe_q <= 1'b0;
      rv_q <= t2_end && ctl.act && !ctl.wr;
      if (t2_end && ctl.act && !ctl.wr) rd_q <= bus_in;
    end
  end

  assign bus_out = wd_q;
  assign bus_oe  = oe_q;
  assign rdata   = rd_q;
  assign rvalid  = rv_q;

  assert_drive_window_R7: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (phase == PH_T2 || phase == PH_T3));
  assert_drive_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (t1_end && ctl.act && ctl.wr) |=> oe_q);
  assert_no_drive_read_R8: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (ctl.act && ctl.wr));
  assert_rvalid_t3_R9: assert property (@(posedge clk) disable iff (rst)
    rv_q |-> (phase == PH_T3 && !oe_q));
endmodule

// File: rtl/xbus_phase_unit.sv
module xbus_phase_unit
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_master_i,
  input  logic          acc_req_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_wr_i,
  input  logic          acc_dspace_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] xa_o,
  output logic          xa_oe_o,
  output logic          msel_o,
  output logic          msel_oe_o,
  output logic [DW-1:0] xd_o,
  output logic          xd_oe_o,
  input  logic [DW-1:0] xd_i
);
  xb_phase_e phase;
  logic      cyc_start;
  logic      t1_end;
  logic      t2_end;
  xb_ctl_t   ctl;

  xbus_phase_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .cyc_start (cyc_start),
    .t1_end    (t1_end),
    .t2_end    (t2_end)
  );

  xbus_addr_drv #(.AW(AW)) adr_i (
    .clk       (clk),
    .rst       (rst),
    .mstr      (bus_master_i),
    .cyc_start (cyc_start),
    .req       (acc_req_i),
    .wr        (acc_wr_i),
    .dsp       (acc_dspace_i),
    .addr_in   (acc_addr_i),
    .ctl       (ctl),
    .addr_o    (xa_o),
    .addr_oe   (xa_oe_o),
    .sel_o     (msel_o),
    .sel_oe    (msel_oe_o)
  );

  xbus_data_drv #(.DW(DW)) dat_i (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .cyc_start (cyc_start),
    .t1_end    (t1_end),
    .t2_end    (t2_end),
    .ctl       (ctl),
    .wdata_in  (acc_wdata_i),
    .bus_in    (xd_i),
    .bus_out   (xd_o),
    .bus_oe    (xd_oe_o),
    .rdata     (rd_data_o),
    .rvalid    (rd_valid_o)
  );

  assign phase_o = phase;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!xa_oe_o && !msel_oe_o && !xd_oe_o && !rd_valid_o));
  assert_pins_agree_R5: assert property (@(posedge clk)
    xa_oe_o == msel_oe_o);
endmodule

// File: tb/xbus_phase_unit_tb_top.sv
module xbus_phase_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mstr = 1'b1;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        dsp = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] xd_in = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [1:0]  phase;
  logic [15:0] xa;
  logic        xa_oe;
  logic        msel;
  logic        msel_oe;
  logic [15:0] xd;
  logic        xd_oe;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  xbus_phase_unit dut_i (
    .clk(clk), .rst(rst), .bus_master_i(mstr), .acc_req_i(req),
    .acc_addr_i(addr), .acc_wr_i(wr), .acc_dspace_i(dsp), .acc_wdata_i(wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .phase_o(phase),
    .xa_o(xa), .xa_oe_o(xa_oe), .msel_o(msel), .msel_oe_o(msel_oe),
    .xd_o(xd), .xd_oe_o(xd_oe), .xd_i(xd_in)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic to_t3();
    for (int i = 0; i < 4 && phase != 2'd3; i++) tick();
  endtask

  // One full access; returns at t3 with the request removed.
  task automatic bus_cycle(input bit w, input bit d, input logic [15:0] a,
                           input logic [15:0] wd, input logic [15:0] bus_rd);
    to_t3();
    req = 1'b1; wr = w; dsp = d; addr = a; wdata = wd;
    tick();
    chk(phase == 2'd0, "R2 t0", phase, 0);
    chk(xa == a, "R3 addr in t0", xa, a);
    chk(msel == !d, "R6 select", msel, !d);
    chk(!xd_oe, "R8 no drive t0", xd_oe, 0);
    req = 1'b0; addr = ~a; wdata = ~wd; wr = !w; dsp = !d;
    tick();
    chk(!xd_oe, "R8 no drive t1", xd_oe, 0);
    xd_in = bus_rd;
    tick();
    chk(xd_oe == w, "R7 drive t2", xd_oe, w);
    if (w) chk(xd == wd, "R7 data t2", xd, wd);
    tick();
    xd_in = 16'h0;
    chk(xd_oe == w, "R7 drive t3", xd_oe, w);
    chk(xa == a, "R3 addr held t3", xa, a);
    chk(msel == !d, "R6 select held", msel, !d);
    chk(rd_valid == !w, "R9 valid t3", rd_valid, !w);
    if (!w) chk(rd_data == bus_rd, "R9 capture", rd_data, bus_rd);
  endtask

  task automatic t_reset();
    tick(); tick();
    chk(!xa_oe && !msel_oe && !xd_oe && !rd_valid, "R1 enables",
        {xa_oe, msel_oe, xd_oe, rd_valid}, 0);
    chk(phase == 2'd0, "R1 phase", phase, 0);
    rst = 1'b0;
    #1;
    chk(phase == 2'd0, "R2 first t0", phase, 0);
    for (int i = 1; i < 6; i++) begin
      tick();
      chk(phase == 2'(i), "R2 advance", phase, 2'(i));
    end
    chk(xa_oe && msel_oe, "R5 master on", {xa_oe, msel_oe}, 3);
  endtask

  task automatic t_write();
    bus_cycle(1'b1, 1'b1, 16'hA55A, 16'h1234, 16'h0);
    tick();
    chk(!xd_oe, "R7 release t0", xd_oe, 0);
    chk(!rd_valid, "R9 no valid after write", rd_valid, 0);
  endtask

  task automatic t_read();
    bus_cycle(1'b0, 1'b0, 16'h0F0F, 16'hFFFF, 16'hBEEF);
    tick();
    chk(!rd_valid, "R9 pulse ends", rd_valid, 0);
  endtask

  task automatic t_idle();
    bus_cycle(1'b1, 1'b1, 16'h4321, 16'h7777, 16'h0);
    req = 1'b0; addr = 16'h9999;
    to_t3();
    tick();
    chk(xa == 16'h4321, "R4 addr hold", xa, 16'h4321);
    chk(msel == 1'b1, "R6 idle high", msel, 1);
    for (int i = 0; i < 4; i++) begin
      chk(!xd_oe, "R8 idle no drive", xd_oe, 0);
      chk(!rd_valid, "R8 idle no valid", rd_valid, 0);
      tick();
    end
  endtask

  task automatic t_no_master();
    to_t3();
    mstr = 1'b0; req = 1'b1; wr = 1'b1; dsp = 1'b1; addr = 16'h2222; wdata = 16'h3333;
    tick();
    chk(!xa_oe && !msel_oe, "R5 master off", {xa_oe, msel_oe}, 0);
    chk(xa != 16'h2222, "R10 addr unchanged", xa, 16'h4321);
    req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!xd_oe && !rd_valid, "R10 refused", {xd_oe, rd_valid}, 0);
      tick();
    end
    mstr = 1'b1;
    tick();
    chk(xa_oe && msel_oe, "R5 master back", {xa_oe, msel_oe}, 3);
  endtask

  task automatic t_back_to_back();
    bus_cycle(1'b0, 1'b1, 16'h0001, 16'h0, 16'hC0DE);
    bus_cycle(1'b1, 1'b0, 16'hFFFE, 16'h5A5A, 16'h0);
    bus_cycle(1'b0, 1'b1, 16'h8000, 16'h0, 16'h0000);
  endtask

  task automatic t_reset_mid();
    to_t3();
    req = 1'b1; wr = 1'b1; addr = 16'h1111;
    tick(); tick(); tick();
    rst = 1'b1;
    tick();
    req = 1'b0;
    chk(!xa_oe && !msel_oe && !xd_oe && !rd_valid, "R1 mid reset",
        {xa_oe, msel_oe, xd_oe, rd_valid}, 0);
    chk(phase == 2'd0, "R1 mid phase", phase, 0);
    rst = 1'b0;
    tick();
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_read();
    t_idle();
    t_no_master();
    t_back_to_back();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule